// File: doc/BRIEF.md
# Hash and Keystream Run Sequencer

This controller steers an external Push/Pull iteration core through the complete command sequence of two operations. In hash mode it takes a message one byte at a time, packs the bytes into 256-bit blocks, appends the padding, pushes every block into the core and runs the finishing Pull tail. The output of the last Pull is held as a 256-bit digest. In keystream mode it pushes a 256-bit key and a 256-bit diversification value, runs the same warm-up tail of blank Pulls, and then hands out one 256-bit keystream block per Pull over a valid/ready handshake.

The core is reached through a command channel (valid/ready, with an operation code and a 256-bit data word) and a response channel (a one-cycle done strobe with the 256-bit Pull output). Only one command is in flight at a time. A run starts with `start` while the sequencer is idle. A keystream run keeps producing blocks until a synchronous reset.

Top module: `hks_sequencer`

## Requirements
- R1: After reset, `busy`, `msg_ready`, `core_cmd_valid`, `ks_valid` and `digest_valid` are all low.
- R2: Every accepted run begins with exactly one Reset command (operation code 0). Push is code 1 and Pull is code 2. A `start` pulse while `busy` is high is ignored.
- R3: Message bytes are packed MSB-first: byte k of a block occupies bits 255-8k down to 248-8k. Each block is sent as one Push carrying exactly that word.
- R4: In the final block, the byte directly after the last message byte is 0x80 and every later byte is zero.
- R5: When the message length is a multiple of 32 bytes, one extra Push follows whose data is 0x80 in bits 255:248 and zero elsewhere.
- R6: After the last Push of a hash run, the sequencer issues exactly 32 Pulls whose output is discarded and then one more Pull. That Pull's output appears on `digest` with `digest_valid` high for one cycle, so a V-block message uses V+34 commands in total, counting the Reset.
- R7: A keystream run issues Reset, then a Push of the key, then a Push of the diversification value, then 32 blank Pulls. Every later Pull output becomes `ks_data`.
- R8: `ks_valid` stays high with `ks_data` unchanged until `ks_ready` is seen. No Pull command is issued while a keystream block is waiting.
- R9: `busy` rises on the cycle after an accepted `start`. It falls together with `digest_valid`, or when the first keystream block becomes valid, and it stays low for the rest of a keystream run.
- R10: `core_cmd_valid` holds with a stable operation and data until `core_cmd_ready`. No new command is offered while a response is pending.
- R11: `msg_ready` is low outside the message phase, for example while idle with `msg_valid` high, and no command results from that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (honoured only when idle) |
| start_mode | input | 1 | 0 = hash, 1 = keystream; sampled with start |
| key_in | input | 256 | Key word, sampled with start |
| div_in | input | 256 | Diversification word, sampled with start |
| msg_valid | input | 1 | Message byte present |
| msg_ready | output | 1 | Message byte accepted this cycle when valid |
| msg_byte | input | 8 | Message byte |
| msg_last | input | 1 | Marks the final message byte |
| busy | output | 1 | Run in progress |
| digest_valid | output | 1 | One-cycle strobe for a new digest |
| digest | output | 256 | Digest word, held until overwritten |
| ks_valid | output | 1 | Keystream block available |
| ks_ready | input | 1 | Consumer takes the keystream block |
| ks_data | output | 256 | Keystream block |
| core_cmd_valid | output | 1 | Command offered to the core |
| core_cmd_ready | input | 1 | Core accepts the command |
| core_cmd_op | output | 2 | 0 Reset, 1 Push, 2 Pull |
| core_cmd_data | output | 256 | Push data (zero otherwise) |
| core_done | input | 1 | Core finished the accepted command |
| core_out | input | 256 | Pull output, valid with core_done |

## Verification
Two events can land on the same clock edge. One is the core accepting a Push of a completely filled last block. The other is the packer forming the extra 0x80 pad block. The 32- and 31-byte messages are run under a core that stalls the command channel on alternate cycles, so the block handover meets back-pressure. The logged Push words are then compared one by one with blocks built from the requirements. The keystream test covers a second overlap: a consumer stall holds `ks_valid` while the next Pull would otherwise go out. It is judged by the command log staying frozen and the data staying stable.

// File: rtl/hks_pkg.sv
`timescale 1ns/1ps
package hks_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_PUSH  = 2'd1,
    OP_PULL  = 2'd2
  } op_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_RESET, PH_KEY, PH_DIV, PH_MSG,
    PH_BLANK, PH_FINAL, PH_KS, PH_HOLD
  } phase_e;
endpackage

// File: rtl/hks_msg_packer.sv
`timescale 1ns/1ps
module hks_msg_packer #(
  parameter int BLK_W = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             en,
  input  logic             byte_valid,
  input  logic [7:0]       byte_in,
  input  logic             byte_last,
  output logic             byte_ready,
  input  logic             take,
  output logic             blk_valid,
  output logic [BLK_W-1:0] blk_data,
  output logic             blk_final
);
  localparam int BYTES = BLK_W / 8;
  localparam int CW    = $clog2(BYTES + 1);

  logic [BLK_W-1:0] blk_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    cnt_nx;
  logic             valid_q, final_q, pad_q, done_q;
  logic             accept;

  assign cnt_nx     = cnt_q + 1'b1;
  assign byte_ready = en && !valid_q && !done_q;
  assign accept     = byte_ready && byte_valid;
  assign blk_valid  = valid_q;
  assign blk_data   = blk_q;
  assign blk_final  = final_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      blk_q   <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      final_q <= 1'b0;
      pad_q   <= 1'b0;
      done_q  <= 1'b0;
    end else if (take && valid_q) begin
      cnt_q <= '0;
      if (pad_q) begin
        blk_q   <= {8'h80, {(BLK_W-8){1'b0}}};
        final_q <= 1'b1;
        pad_q   <= 1'b0;
      end else begin
        blk_q   <= '0;
        valid_q <= 1'b0;
        final_q <= 1'b0;
      end
    end else if (accept) begin
      for (int i = 0; i < BYTES; i++) begin
        if (CW'(i) == cnt_q)
          blk_q[BLK_W-1-8*i -: 8] <= byte_in;
        else if (byte_last && CW'(i) == cnt_nx)
          blk_q[BLK_W-1-8*i -: 8] <= 8'h80;
      end
      cnt_q <= cnt_nx;
      if (byte_last || cnt_nx == CW'(BYTES)) begin
        valid_q <= 1'b1;
        final_q <= byte_last && (cnt_nx != CW'(BYTES));
        pad_q   <= byte_last && (cnt_nx == CW'(BYTES));
      end
      done_q <= byte_last;
    end
  end

  assert_block_hold_R3: assert property (@(posedge clk) disable iff (rst || clear)
    valid_q && !take |=> valid_q && $stable(blk_q));
  assert_pad_waits_R5: assert property (@(posedge clk) disable iff (rst)
    pad_q |-> valid_q && !final_q);
endmodule

// File: rtl/hks_tail_counter.sv
`timescale 1ns/1ps
module hks_tail_counter #(
  parameter int TAIL = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic dec,
  output logic last
);
  localparam int CW = $clog2(TAIL + 1);
  logic [CW-1:0] cnt_q;

  assign last = (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= CW'(TAIL);
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    dec |-> cnt_q != '0);
endmodule

// File: rtl/hks_out_stage.sv
`timescale 1ns/1ps
module hks_out_stage #(
  parameter int BLK_W = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dig_load,
  input  logic             ks_load,
  input  logic [BLK_W-1:0] din,
  input  logic             ks_ready,
  output logic [BLK_W-1:0] digest,
  output logic             digest_valid,
  output logic             ks_valid,
  output logic [BLK_W-1:0] ks_data,
  output logic             ks_take
);
  assign ks_take = ks_valid && ks_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      digest       <= '0;
      digest_valid <= 1'b0;
      ks_valid     <= 1'b0;
      ks_data      <= '0;
    end else begin
      digest_valid <= dig_load;
      if (dig_load) digest <= din;
      if (ks_load) begin
        ks_valid <= 1'b1;
        ks_data  <= din;
      end else if (ks_take) begin
        ks_valid <= 1'b0;
      end
    end
  end

  assert_ks_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ks_valid && !ks_ready |=> ks_valid && $stable(ks_data));
endmodule

// File: rtl/hks_sequencer.sv
`timescale 1ns/1ps
module hks_sequencer #(
  parameter int BLK_W      = 256,
  parameter int TAIL_PULLS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_mode,
  input  logic [BLK_W-1:0] key_in,
  input  logic [BLK_W-1:0] div_in,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic [7:0]       msg_byte,
  input  logic             msg_last,
  output logic             busy,
  output logic             digest_valid,
  output logic [BLK_W-1:0] digest,
  output logic             ks_valid,
  input  logic             ks_ready,
  output logic [BLK_W-1:0] ks_data,
  output logic             core_cmd_valid,
  input  logic             core_cmd_ready,
  output logic [1:0]       core_cmd_op,
  output logic [BLK_W-1:0] core_cmd_data,
  input  logic             core_done,
  input  logic [BLK_W-1:0] core_out
);
  import hks_pkg::*;

  phase_e           phase_q;
  logic             mode_q, waiting_q, cmd_v_q, last_blk_q, busy_q;
  op_e              cmd_op_q;
  logic [BLK_W-1:0] cmd_data_q, key_q, div_q;

  logic             start_ok, resp, want, can_issue, cmd_fire;
  op_e              want_op;
  logic [BLK_W-1:0] want_data;
  logic             blk_valid, blk_final, tail_last, ks_take;
  logic [BLK_W-1:0] blk_data;
  logic             tail_load, tail_dec, dig_load, ks_load;

  assign start_ok  = start && (phase_q == PH_IDLE);
  assign resp      = waiting_q && core_done;
  assign cmd_fire  = cmd_v_q && core_cmd_ready;
  assign tail_load = resp && ((phase_q == PH_DIV) || (phase_q == PH_MSG && last_blk_q));
  assign tail_dec  = resp && (phase_q == PH_BLANK);
  assign dig_load  = resp && (phase_q == PH_FINAL);
  assign ks_load   = resp && (phase_q == PH_KS);

  always_comb begin
    want      = 1'b0;
    want_op   = OP_PULL;
    want_data = '0;
    unique case (phase_q)
      PH_RESET: begin want = 1'b1; want_op = OP_RESET; end
      PH_KEY:   begin want = 1'b1; want_op = OP_PUSH; want_data = key_q; end
      PH_DIV:   begin want = 1'b1; want_op = OP_PUSH; want_data = div_q; end
      PH_MSG:   begin want = blk_valid; want_op = OP_PUSH; want_data = blk_data; end
      PH_BLANK, PH_FINAL, PH_KS: want = 1'b1;
      default: want = 1'b0;
    endcase
  end

  assign can_issue = want && !cmd_v_q && !waiting_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      mode_q     <= 1'b0;
      waiting_q  <= 1'b0;
      cmd_v_q    <= 1'b0;
      cmd_op_q   <= OP_RESET;
      cmd_data_q <= '0;
      key_q      <= '0;
      div_q      <= '0;
      last_blk_q <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      if (start_ok) begin
        phase_q <= PH_RESET;
        mode_q  <= start_mode;
        key_q   <= key_in;
        div_q   <= div_in;
        busy_q  <= 1'b1;
      end
      if (can_issue) begin
        cmd_v_q    <= 1'b1;
        cmd_op_q   <= want_op;
        cmd_data_q <= want_data;
        if (phase_q == PH_MSG) last_blk_q <= blk_final;
      end
      if (cmd_fire) begin
        cmd_v_q   <= 1'b0;
        waiting_q <= 1'b1;
      end
      if (resp) begin
        waiting_q <= 1'b0;
        unique case (phase_q)
          PH_RESET: phase_q <= mode_q ? PH_KEY : PH_MSG;
          PH_KEY:   phase_q <= PH_DIV;
          PH_DIV:   phase_q <= PH_BLANK;
          PH_MSG:   if (last_blk_q) phase_q <= PH_BLANK;
          PH_BLANK: if (tail_last) phase_q <= mode_q ? PH_KS : PH_FINAL;
          PH_FINAL: begin phase_q <= PH_IDLE; busy_q <= 1'b0; end
          PH_KS:    begin phase_q <= PH_HOLD; busy_q <= 1'b0; end
          default:  phase_q <= phase_q;
        endcase
      end
      if (phase_q == PH_HOLD && ks_take) phase_q <= PH_KS;
    end
  end

  hks_msg_packer #(.BLK_W(BLK_W)) u_packer (
    .clk        (clk),
    .rst        (rst),
    .clear      (start_ok),
    .en         (phase_q == PH_MSG),
    .byte_valid (msg_valid),
    .byte_in    (msg_byte),
    .byte_last  (msg_last),
    .byte_ready (msg_ready),
    .take       (cmd_fire && phase_q == PH_MSG),
    .blk_valid  (blk_valid),
    .blk_data   (blk_data),
    .blk_final  (blk_final)
  );

  hks_tail_counter #(.TAIL(TAIL_PULLS)) u_tail (
    .clk  (clk),
    .rst  (rst),
    .load (tail_load),
    .dec  (tail_dec),
    .last (tail_last)
  );

  hks_out_stage #(.BLK_W(BLK_W)) u_out (
    .clk          (clk),
    .rst          (rst),
    .dig_load     (dig_load),
    .ks_load      (ks_load),
    .din          (core_out),
    .ks_ready     (ks_ready),
    .digest       (digest),
    .digest_valid (digest_valid),
    .ks_valid     (ks_valid),
    .ks_data      (ks_data),
    .ks_take      (ks_take)
  );

  assign busy           = busy_q;
  assign core_cmd_valid = cmd_v_q;
  assign core_cmd_op    = cmd_op_q;
  assign core_cmd_data  = cmd_data_q;

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    core_cmd_valid && !core_cmd_ready |=>
      core_cmd_valid && $stable(core_cmd_op) && $stable(core_cmd_data));
  assert_single_flight_R10: assert property (@(posedge clk) disable iff (rst)
    core_done |-> !core_cmd_valid);
  assert_stall_pull_R8: assert property (@(posedge clk) disable iff (rst)
    ks_valid |-> !core_cmd_valid);
  assert_busy_end_R9: assert property (@(posedge clk) disable iff (rst)
    digest_valid |-> !busy);
  assert_msg_gate_R11: assert property (@(posedge clk) disable iff (rst)
    msg_ready |-> !core_cmd_valid);
endmodule

// File: tb/tb_hks_sequencer.sv
`timescale 1ns/1ps
module tb_hks_sequencer;
  localparam int W = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, start_mode = 1'b0;
  logic [W-1:0] key_in = '0, div_in = '0;
  logic msg_valid = 1'b0, msg_last = 1'b0;
  logic [7:0] msg_byte = '0;
  logic msg_ready, busy, digest_valid, ks_valid;
  logic ks_ready = 1'b0;
  logic [W-1:0] digest, ks_data;
  logic core_cmd_valid;
  logic core_cmd_ready;
  logic [1:0] core_cmd_op;
  logic [W-1:0] core_cmd_data;
  logic core_done;
  logic [W-1:0] core_out;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  hks_sequencer dut (
    .clk(clk), .rst(rst), .start(start), .start_mode(start_mode),
    .key_in(key_in), .div_in(div_in),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_byte(msg_byte), .msg_last(msg_last),
    .busy(busy), .digest_valid(digest_valid), .digest(digest),
    .ks_valid(ks_valid), .ks_ready(ks_ready), .ks_data(ks_data),
    .core_cmd_valid(core_cmd_valid), .core_cmd_ready(core_cmd_ready),
    .core_cmd_op(core_cmd_op), .core_cmd_data(core_cmd_data),
    .core_done(core_done), .core_out(core_out)
  );

  // Behavioural core model with a command log
  logic [1:0]   lg_op  [0:127];
  logic [W-1:0] lg_dat [0:127];
  int           log_n;
  logic [W-1:0] m_acc;
  logic [31:0]  m_pk;
  logic [1:0]   m_del;
  logic [31:0]  tick;
  logic         slow = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      log_n <= 0; m_acc <= '0; m_pk <= '0; m_del <= '0; tick <= '0;
      core_done <= 1'b0; core_out <= '0; core_cmd_ready <= 1'b0;
    end else begin
      tick <= tick + 1;
      core_cmd_ready <= slow ? tick[0] : 1'b1;
      core_done <= 1'b0;
      if (core_cmd_valid && core_cmd_ready) begin
        if (log_n < 128) begin
          lg_op[log_n]  <= core_cmd_op;
          lg_dat[log_n] <= core_cmd_data;
        end
        log_n <= log_n + 1;
        case (core_cmd_op)
          2'd0: begin m_acc <= '0; m_pk <= '0; end
          2'd1: m_acc <= m_acc ^ core_cmd_data;
          default: begin core_out <= m_acc ^ {8{m_pk + 32'd1}}; m_pk <= m_pk + 32'd1; end
        endcase
        m_del <= 2'd2;
      end else if (m_del != 0) begin
        m_del <= m_del - 2'd1;
        if (m_del == 2'd1) core_done <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0; msg_valid = 1'b0; msg_last = 1'b0; ks_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] msgb(int i, int len);
    return 8'(i * 13 + len * 3 + 5);
  endfunction

  task automatic pulse_start(input bit mode);
    start = 1'b1; start_mode = mode;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic test_reset_state();
    do_reset();
    chk(!busy && !msg_ready && !core_cmd_valid && !ks_valid && !digest_valid, "R1 reset outputs",
        W'({busy, msg_ready, core_cmd_valid, ks_valid, digest_valid}), '0);
  endtask

  task automatic run_hash(input int len, input bit slw, input bit poke);
    int v, wd;
    logic [W-1:0] blk, acc;
    logic [7:0] b;
    int base;
    do_reset();
    slow = slw;
    @(negedge clk);
    pulse_start(1'b0);
    chk(busy == 1'b1, "R9 busy after start", W'(busy), W'(1));
    if (poke) pulse_start(1'b1); // R2: must be ignored while busy
    for (int i = 0; i < len; i++) begin
      msg_valid = 1'b1; msg_byte = msgb(i, len); msg_last = (i == len - 1);
      wd = 0;
      while (!msg_ready && wd < 2000) begin @(negedge clk); wd++; end
      @(negedge clk);
    end
    msg_valid = 1'b0; msg_last = 1'b0;
    wd = 0;
    while (!digest_valid && wd < 4000) begin @(negedge clk); wd++; end
    chk(digest_valid, "R6 digest strobe seen", W'(digest_valid), W'(1));
    chk(!busy, "R9 busy low with digest", W'(busy), '0);
    v = len / 32 + 1;
    chk(log_n == v + 34, "R6 command count", W'(log_n), W'(v + 34));
    chk(lg_op[0] == 2'd0, "R2 first command is Reset", W'(lg_op[0]), '0);
    acc = '0;
    for (int j = 0; j < v; j++) begin
      blk = '0;
      for (int i = 0; i < 32; i++) begin
        base = 32 * j + i;
        b = (base < len) ? msgb(base, len) : ((base == len) ? 8'h80 : 8'h00);
        blk[W-1-8*i -: 8] = b;
      end
      acc ^= blk;
      chk(lg_op[1+j] == 2'd1 && lg_dat[1+j] == blk,
          (j == v - 1) ? ((len % 32 == 0) ? "R5 pad-only block" : "R4 padded final block") : "R3 packed block",
          lg_dat[1+j], blk);
    end
    for (int k = 0; k < 33; k++)
      if (lg_op[1+v+k] != 2'd2)
        chk(1'b0, "R6 tail Pull", W'(lg_op[1+v+k]), W'(2));
    checks++;
    chk(digest == (acc ^ {8{32'd33}}), "R6 digest value", digest, acc ^ {8{32'd33}});
    // R11: idle sequencer ignores message bytes
    msg_valid = 1'b1; msg_byte = 8'hAA; msg_last = 1'b1;
    base = log_n;
    repeat (3) begin
      @(negedge clk);
      chk(!msg_ready, "R11 msg_ready low while idle", W'(msg_ready), '0);
    end
    chk(log_n == base, "R11 no command while idle", W'(log_n), W'(base));
    msg_valid = 1'b0; msg_last = 1'b0;
  endtask

  task automatic run_stream();
    int wd, n0;
    logic [W-1:0] kd, hold;
    do_reset();
    slow = 1'b1;
    key_in = {8{32'h1234_5678}} ^ {W{1'b0}} ^ {4{64'h0F0F_1111_2222_3333}};
    div_in = {8{32'hCAFE_0001}};
    kd = key_in ^ div_in;
    @(negedge clk);
    pulse_start(1'b1);
    chk(busy, "R9 busy during warm-up", W'(busy), W'(1));
    wd = 0;
    while (!ks_valid && wd < 4000) begin @(negedge clk); wd++; end
    chk(!busy, "R9 busy low at first block", W'(busy), '0);
    chk(log_n == 36, "R7 warm-up command count", W'(log_n), W'(36));
    chk(lg_op[0] == 2'd0 && lg_op[1] == 2'd1 && lg_dat[1] == key_in, "R7 key push", lg_dat[1], key_in);
    chk(lg_op[2] == 2'd1 && lg_dat[2] == div_in, "R7 div push", lg_dat[2], div_in);
    for (int k = 3; k < 36; k++)
      if (lg_op[k] != 2'd2) chk(1'b0, "R7 Pull sequence", W'(lg_op[k]), W'(2));
    checks++;
    chk(ks_data == (kd ^ {8{32'd33}}), "R7 first keystream block", ks_data, kd ^ {8{32'd33}});
    hold = ks_data; n0 = log_n;
    repeat (6) @(negedge clk);
    chk(ks_valid && ks_data == hold, "R8 block held under stall", ks_data, hold);
    chk(log_n == n0, "R8 no Pull while stalled", W'(log_n), W'(n0));
    for (int blkn = 34; blkn < 37; blkn++) begin
      ks_ready = 1'b1;
      @(negedge clk);
      ks_ready = 1'b0;
      wd = 0;
      while (!ks_valid && wd < 500) begin @(negedge clk); wd++; end
      chk(ks_data == (kd ^ {8{32'(blkn)}}), "R7 next keystream block", ks_data, kd ^ {8{32'(blkn)}});
      chk(!busy, "R9 busy stays low", W'(busy), '0);
    end
    slow = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    test_reset_state();
    run_hash(5, 1'b0, 1'b1);
    run_hash(31, 1'b1, 1'b0);
    run_hash(32, 1'b1, 1'b0);
    run_hash(45, 1'b0, 1'b0);
    run_hash(64, 1'b1, 1'b0);
    run_stream();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule